// File: doc/BRIEF.md
# Ethernet PHY management register model

This block models the management register set of one Ethernet PHY as seen through a plain register port. The port uses a 5-bit register number and 16-bit data. The block keeps five writable or self-updating registers: control, status, advertisement, interrupt mask and interrupt source. It answers a few further addresses with fixed identification and partner-ability values. Every other address reads as zero, and writes to those addresses are dropped. It does not model pin-level serial framing or real negotiation.

A `link_up` level from the surrounding system drives the status and interrupt-source bits. Each change of that level, and the first clock after any reset, updates the status bits and the event bits together. The `irq` output goes high whenever a source bit is set under a set mask bit. Reading the source register returns its value and clears it in the same access. A write to the control register with bit 15 set restores every register to its reset value.

Requests use a valid/ready handshake. `req_ready` is held high, so the block never applies back-pressure and a request is taken in every cycle that `req_valid` is high. Each accepted request gets a response one cycle later. The response has no ready signal, so the requester must accept it in that cycle.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset the control register (address 0) reads 0x3000, advertisement (address 4) reads 0x01E1, and mask (address 30) and source (address 29) are 0. Status (address 1) starts at 0x7809. The first clock after reset applies the current `link_up` level as a link event (R2/R3).
- R2: On a link event with `link_up` high, status bits 2 and 5 are set and source bits 7 and 6 are set. A link event is a change of `link_up` from the previous cycle, or the first cycle after a reset.
- R3: On a link event with `link_up` low, status bits 2 and 5 are cleared and source bit 4 is set.
- R4: Address 2 reads 0x0007, address 3 reads 0xC0D1, address 5 reads 0x0F71 and address 6 reads 0x0001.
- R5: A read of address 29 returns the source value held before the access and clears the register. If a link event falls in the same cycle, its bits are set after the clear and remain set.
- R6: A write to address 0 with bit 15 set restores all registers to their R1 values, and the following cycle applies the link level. Any other write to address 0 stores the data ANDed with 0x7980. If data bit 12 is also set, status bit 5 is set.
- R7: A write to address 4 stores (data AND 0x2D7F) OR 0x0080. A write to address 30 stores data bits 7:0 as the mask, which reads back zero-extended.
- R8: Writes to addresses 1, 2, 3, 5, 6, 29 and all unlisted addresses (for example 7, 17, 18, 27, 31) change nothing. Unlisted addresses read as 0.
- R9: `irq` is high exactly when (source AND mask) is nonzero. It follows the register state updated at the same clock edge.
- R10: `req_ready` is always high. Each accepted request raises `rsp_valid` for exactly one cycle, on the cycle after acceptance. `rsp_rdata` carries the read value for a read and 0 for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (constant high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| link_up | input | 1 | Current link level |
| irq | output | 1 | Masked interrupt-source indicator |

## Verification
The clear-on-read of the source register can coincide with a link event. To provoke this, the bench switches `link_up` in the same cycle that a read of address 29 is presented. The returned data must be the old source value. A second read must then show exactly the event bits of the new link level, which proves that the clear did not remove the event. A soft reset written while the link level is unchanged is also checked: the link bits must be re-applied on the following clock. A behavioural model compares `rsp_valid`, `rsp_rdata` and `irq` on every clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam logic [4:0] A_CTRL    = 5'd0;
  localparam logic [4:0] A_STAT    = 5'd1;
  localparam logic [4:0] A_ID_HI   = 5'd2;
  localparam logic [4:0] A_ID_LO   = 5'd3;
  localparam logic [4:0] A_ADV     = 5'd4;
  localparam logic [4:0] A_PARTNER = 5'd5;
  localparam logic [4:0] A_EXPAND  = 5'd6;
  localparam logic [4:0] A_SRC     = 5'd29;
  localparam logic [4:0] A_MASK    = 5'd30;

  localparam logic [15:0] RST_CTRL = 16'h3000;
  localparam logic [15:0] RST_STAT = 16'h7809;
  localparam logic [15:0] RST_ADV  = 16'h01E1;

  localparam logic [15:0] CTRL_KEEP = 16'h7980;
  localparam logic [15:0] ADV_KEEP  = 16'h2D7F;
  localparam logic [15:0] ADV_FORCE = 16'h0080;

  localparam logic [15:0] ID_HI_VAL   = 16'h0007;
  localparam logic [15:0] ID_LO_VAL   = 16'hC0D1;
  localparam logic [15:0] PARTNER_VAL = 16'h0F71;
  localparam logic [15:0] EXPAND_VAL  = 16'h0001;

  localparam int unsigned CTRL_SOFT_RST_BIT = 15;
  localparam int unsigned CTRL_NEG_BIT      = 12;

  localparam logic [15:0] STAT_LINK_BITS = 16'h0024;
  localparam logic [15:0] STAT_NEG_DONE  = 16'h0020;

  localparam logic [7:0] SRC_UP_BITS   = 8'hC0;
  localparam logic [7:0] SRC_DOWN_BITS = 8'h10;

  typedef struct packed {
    logic soft_rst;
    logic wr_ctrl;
    logic wr_adv;
    logic wr_mask;
    logic rd_src;
  } strobe_t;

endpackage

// File: rtl/phy_link_tracker.sv
module phy_link_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic link_up,
  output logic evt_up,
  output logic evt_down
);
  logic armed_q;
  logic prev_q;
  logic apply;

  assign apply    = !restart && (!armed_q || (link_up != prev_q));
  assign evt_up   = apply && link_up;
  assign evt_down = apply && !link_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      armed_q <= !restart;
      prev_q  <= link_up;
    end
  end

  // R6
  relink_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (restart || evt_up || evt_down));

  // R2
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_up && evt_down));

endmodule

// File: rtl/phy_req_decode.sv
module phy_req_decode
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           stb
);
  logic wr;
  logic rd;

  assign wr = fire && is_write;
  assign rd = fire && !is_write;

  always_comb begin
    stb          = '0;
    stb.soft_rst = wr && (addr == ADDR_W'(A_CTRL)) &&  wdata[CTRL_SOFT_RST_BIT];
    stb.wr_ctrl  = wr && (addr == ADDR_W'(A_CTRL)) && !wdata[CTRL_SOFT_RST_BIT];
    stb.wr_adv   = wr && (addr == ADDR_W'(A_ADV));
    stb.wr_mask  = wr && (addr == ADDR_W'(A_MASK));
    stb.rd_src   = rd && (addr == ADDR_W'(A_SRC));
  end

  // R8
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

endmodule

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IRQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_up,
  input  logic              evt_down,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] adv_q,
  output logic [IRQ_W-1:0]  mask_q,
  output logic [IRQ_W-1:0]  src_q
);
  logic [DATA_W-1:0] stat_n;
  logic [IRQ_W-1:0]  src_n;

  always_comb begin
    stat_n = stat_q;
    if (stb.wr_ctrl && wdata[CTRL_NEG_BIT]) stat_n = stat_n | DATA_W'(STAT_NEG_DONE);
    if (evt_up)   stat_n = stat_n | DATA_W'(STAT_LINK_BITS);
    if (evt_down) stat_n = stat_n & ~DATA_W'(STAT_LINK_BITS);

    src_n = stb.rd_src ? '0 : src_q;
    if (evt_up)   src_n = src_n | IRQ_W'(SRC_UP_BITS);
    if (evt_down) src_n = src_n | IRQ_W'(SRC_DOWN_BITS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.soft_rst) begin
      ctrl_q <= DATA_W'(RST_CTRL);
      stat_q <= DATA_W'(RST_STAT);
      adv_q  <= DATA_W'(RST_ADV);
      mask_q <= '0;
      src_q  <= '0;
    end else begin
      stat_q <= stat_n;
      src_q  <= src_n;
      if (stb.wr_ctrl) ctrl_q <= wdata & DATA_W'(CTRL_KEEP);
      if (stb.wr_adv)  adv_q  <= (wdata & DATA_W'(ADV_KEEP)) | DATA_W'(ADV_FORCE);
      if (stb.wr_mask) mask_q <= wdata[IRQ_W-1:0];
    end
  end

  // R5
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rd_src && !evt_up && !evt_down) |=> (src_q == '0));

  // R2
  link_up_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_up |=> (stat_q[2] && stat_q[5] && src_q[7] && src_q[6]));

  // R3
  link_down_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_down |=> (!stat_q[2] && !stat_q[5] && src_q[4]));

  // R6
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.soft_rst |=> (ctrl_q == DATA_W'(RST_CTRL) && mask_q == '0 && src_q == '0));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.wr_mask && !stb.soft_rst) |=> $stable(mask_q));

endmodule

// File: rtl/phy_rd_mux.sv
module phy_rd_mux
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IRQ_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] adv_q,
  input  logic [IRQ_W-1:0]  mask_q,
  input  logic [IRQ_W-1:0]  src_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    unique case (addr)
      ADDR_W'(A_CTRL):    rdata = ctrl_q;
      ADDR_W'(A_STAT):    rdata = stat_q;
      ADDR_W'(A_ID_HI):   rdata = DATA_W'(ID_HI_VAL);
      ADDR_W'(A_ID_LO):   rdata = DATA_W'(ID_LO_VAL);
      ADDR_W'(A_ADV):     rdata = adv_q;
      ADDR_W'(A_PARTNER): rdata = DATA_W'(PARTNER_VAL);
      ADDR_W'(A_EXPAND):  rdata = DATA_W'(EXPAND_VAL);
      ADDR_W'(A_SRC):     rdata = DATA_W'(src_q);
      ADDR_W'(A_MASK):    rdata = DATA_W'(mask_q);
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IRQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              link_up,
  output logic              irq
);
  logic              fire;
  strobe_t           stb;
  logic              evt_up;
  logic              evt_down;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] adv_q;
  logic [IRQ_W-1:0]  mask_q;
  logic [IRQ_W-1:0]  src_q;
  logic [DATA_W-1:0] rd_val;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;

  phy_req_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .is_write(req_write),
    .addr(req_addr), .wdata(req_wdata), .stb(stb)
  );

  phy_link_tracker u_link (
    .clk(clk), .rst_n(rst_n), .restart(stb.soft_rst), .link_up(link_up),
    .evt_up(evt_up), .evt_down(evt_down)
  );

  phy_reg_store #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_store (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(req_wdata),
    .evt_up(evt_up), .evt_down(evt_down),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .adv_q(adv_q),
    .mask_q(mask_q), .src_q(src_q)
  );

  phy_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_mux (
    .addr(req_addr), .ctrl_q(ctrl_q), .stat_q(stat_q), .adv_q(adv_q),
    .mask_q(mask_q), .src_q(src_q), .rdata(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= fire;
      rsp_rdata <= (fire && !req_write) ? rd_val : '0;
    end
  end

  assign irq = |(src_q & mask_q);

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !rsp_valid);

  // R10
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |=> (rsp_rdata == '0));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (src_q != '0 && mask_q != '0));

endmodule

// File: tb/sim_phy_mgmt_regs.sv
`timescale 1ns/1ps
module sim_phy_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        link_up = 1'b1;
  logic        irq;

  always #2 clk = ~clk;

  phy_mgmt_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .link_up(link_up), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural reference
  int m_ctrl, m_stat, m_adv, m_mask, m_src;
  bit m_armed, m_prev;
  bit e_rv;
  int e_rd;
  int ma, md;
  bit m_wr, m_rd;

  function automatic int m_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_stat;
      2: return 'h0007;
      3: return 'hC0D1;
      4: return m_adv;
      5: return 'h0F71;
      6: return 'h0001;
      29: return m_src;
      30: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset_vals();
    m_ctrl = 'h3000; m_stat = 'h7809; m_adv = 'h01E1; m_mask = 0; m_src = 0;
    m_armed = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset_vals();
      m_prev = 0; e_rv = 0; e_rd = 0;
    end else begin
      ma = int'(req_addr); md = int'(req_wdata);
      m_wr = req_valid && req_write;
      m_rd = req_valid && !req_write;
      e_rv = req_valid;
      e_rd = m_rd ? m_read(ma) : 0;
      if (m_wr && ma == 0 && (md & 'h8000) != 0) begin
        m_reset_vals();
        m_prev = link_up;
      end else begin
        if (m_rd && ma == 29) m_src = 0;
        if (m_wr) begin
          if (ma == 0) begin
            m_ctrl = md & 'h7980;
            if ((md & 'h1000) != 0) m_stat = m_stat | 'h20;
          end else if (ma == 4) m_adv = (md & 'h2D7F) | 'h80;
          else if (ma == 30) m_mask = md & 'hFF;
        end
        if (!m_armed || link_up != m_prev) begin
          if (link_up) begin m_stat = m_stat | 'h24; m_src = m_src | 'hC0; end
          else begin m_stat = m_stat & ~'h24; m_src = m_src | 'h10; end
        end
        m_armed = 1; m_prev = link_up;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (rsp_valid !== e_rv || int'(rsp_rdata) != e_rd ||
          irq !== ((m_src & m_mask) != 0) || req_ready !== 1'b1) begin
        n_fail++;
        $display("FAIL R9/R10 model: act v=%0b d=%h irq=%0b rdy=%0b exp v=%0b d=%h irq=%0b rdy=1",
                 rsp_valid, rsp_rdata, irq, req_ready, e_rv, e_rd[15:0],
                 ((m_src & m_mask) != 0));
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 5'(a);
    @(negedge clk);
    v = int'(rsp_rdata);
    req_valid = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 5'(a); req_wdata = 16'(d);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v;
    link_up = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2: reset values with link applied
    rd(0, v);  chk("R1 ctrl reset", v, 'h3000);
    rd(4, v);  chk("R1 adv reset", v, 'h01E1);
    rd(30, v); chk("R1 mask reset", v, 0);
    rd(1, v);  chk("R2 status link up", v, 'h782D);
    chk("R9 irq masked off", int'(irq), 0);
    // R4 fixed values
    rd(2, v); chk("R4 id hi", v, 'h0007);
    rd(3, v); chk("R4 id lo", v, 'hC0D1);
    rd(5, v); chk("R4 partner", v, 'h0F71);
    rd(6, v); chk("R4 expansion", v, 'h0001);
    // R7 mask write, R9 irq
    wr(30, 'hFFD0);
    chk("R9 irq on", int'(irq), 1);
    rd(30, v); chk("R7 mask readback", v, 'h00D0);
    // R5 clear on read
    rd(29, v); chk("R5 source up bits", v, 'h00C0);
    rd(29, v); chk("R5 source cleared", v, 0);
    chk("R9 irq off", int'(irq), 0);
    // R3 link down
    @(negedge clk); link_up = 0;
    idle(2);
    chk("R9 irq down event", int'(irq), 1);
    rd(1, v);  chk("R3 status link down", v, 'h7809);
    rd(29, v); chk("R3 source down bit", v, 'h0010);
    // R7 advertisement
    wr(4, 'hFFFF); rd(4, v); chk("R7 adv all ones", v, 'h2DFF);
    wr(4, 0);      rd(4, v); chk("R7 adv bit7 forced", v, 'h0080);
    // R6 control write and negotiation bit
    wr(0, 'h1200); rd(0, v); chk("R6 ctrl masked", v, 'h1000);
    rd(1, v); chk("R6 neg done bit", v, 'h7829);
    // R8 ignored writes
    wr(1, 0);      rd(1, v);  chk("R8 status write ignored", v, 'h7829);
    wr(2, 'h1234); rd(2, v);  chk("R8 id write ignored", v, 'h0007);
    wr(17, 'hFFFF); rd(17, v); chk("R8 reg17 zero", v, 0);
    rd(31, v); chk("R8 reg31 zero", v, 0);
    rd(7, v);  chk("R8 reg7 zero", v, 0);
    rd(0, v);  chk("R8 ctrl untouched", v, 'h1000);
    // R10 write response
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 5'd27; req_wdata = 16'hABCD;
    @(negedge clk);
    req_valid = 0;
    chk("R10 write rsp valid", int'(rsp_valid), 1);
    chk("R10 write rsp data", int'(rsp_rdata), 0);
    @(negedge clk);
    chk("R10 rsp single cycle", int'(rsp_valid), 0);
    // R6 soft reset, link still down
    wr(30, 'hFF);
    wr(4, 'h0000);
    wr(0, 'h8000);
    rd(0, v);  chk("R6 soft ctrl", v, 'h3000);
    rd(4, v);  chk("R6 soft adv", v, 'h01E1);
    rd(30, v); chk("R6 soft mask", v, 0);
    rd(1, v);  chk("R6 soft status relinked", v, 'h7809);
    rd(29, v); chk("R6 soft source relinked", v, 'h0010);
    // R5 collision: clear-on-read with link event in same cycle
    @(negedge clk); link_up = 1;
    idle(2);
    @(negedge clk); link_up = 0;
    idle(2);
    @(negedge clk);
    link_up = 1;
    req_valid = 1; req_write = 0; req_addr = 5'd29;
    @(negedge clk);
    v = int'(rsp_rdata);
    req_valid = 0;
    chk("R5 collision old value", v, 'h00D0);
    rd(29, v); chk("R5 collision event kept", v, 'h00C0);
    // back-to-back requests against model
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      req_valid = 1; req_write = i[0]; req_addr = 5'(i % 32); req_wdata = 16'(i * 16'h0911);
      if (i == 20) link_up = 0;
      @(negedge clk);
    end
    req_valid = 0;
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule